// File: doc/BRIEF.md
# TDM Multichannel Input Frame Checker

This block sits in front of a time-division-multiplexed multichannel filter datapath and polices the shape of its input stream. The stream is one data word per clock with a valid flag. One TDM period lasts `TDM_FACTOR` clocks, which is the clock rate divided by the per-channel sample rate. Each period must carry one contiguous block of exactly `NUM_CHANS` valid words, one word per channel and with no hole, followed by idle cycles that fill out the period. The idle gap may be longer than the minimum of `TDM_FACTOR - NUM_CHANS` cycles, but never shorter.

Each accepted word is forwarded one clock later. It carries its channel index, which counts 0 to `NUM_CHANS-1` within the block, and a start-of-block pulse on channel 0. A word that arrives too early after the previous block is a violation, and so is a valid flag that drops inside a block. Either one sets a sticky format error and stops all forwarding until reset. An active-low synchronous reset returns the checker to waiting for a first block, and that first block needs no idle gap ahead of it.

With the default parameters (a period of 32 clocks and 15 channels) the checker expects 15 valid cycles, then at least 17 idle cycles, and so on.

Top module: `tdm_frame_checker`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises, `outValid`, `outSob` and `fmtError` are 0 and `outChan` is 0.
- R2: A word accepted on a clock edge appears on `outData` with `outValid` high in the cycle after that edge, unchanged.
- R3: Within a block, `outChan` takes the values 0, 1, … `NUM_CHANS-1` in order, and `outSob` is 1 exactly when channel 0 is forwarded.
- R4: After reset, the first valid word starts a block at once, with no idle gap required before it.
- R5: An idle gap of exactly `TDM_FACTOR - NUM_CHANS` cycles between blocks is accepted, and the next block is forwarded normally.
- R6: An idle gap longer than the minimum is accepted, and the next block is forwarded normally.
- R7: A valid word that arrives after fewer than `TDM_FACTOR - NUM_CHANS` idle cycles (zero idle cycles included) is not forwarded. `fmtError` is 1 from the cycle after that word.
- R8: If the valid flag is low on any cycle after channel 0 and before channel `NUM_CHANS-1` of a block, `fmtError` becomes 1 in the next cycle. No later word of that block is forwarded.
- R9: Once `fmtError` is 1, it stays 1 and `outValid` stays 0 until reset, whatever the input does.
- R10: A reset clears `fmtError` and returns the checker to waiting for a first block, which is then accepted without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input word present this cycle |
| inData | input | DATA_W | Input data word |
| outValid | output | 1 | Forwarded word present |
| outData | output | DATA_W | Forwarded data word |
| outChan | output | $clog2(NUM_CHANS) (at least 1) | Channel index of forwarded word |
| outSob | output | 1 | Start of block, set with channel 0 |
| fmtError | output | 1 | Sticky format violation flag |

## Verification
A wrong channel counter shows up at once on `outChan`, and on `outSob` at the next block boundary. A gap counter that counts wrongly shows at the first block that follows an idle run near the minimum length: either a legal block raises `fmtError`, or an early word gets through with `outValid`. A state machine that leaves its fault state would let `outValid` rise again after an error, which is visible within the next block. The bench therefore runs gaps one cycle below the minimum, exactly at it and above it, and checks every forwarded word cycle by cycle.

// File: rtl/tdm_frame_pkg.sv
package tdm_frame_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_FIRST = 2'd0,
    ST_IN_BLOCK   = 2'd1,
    ST_IN_GAP     = 2'd2,
    ST_FAULT      = 2'd3
  } frame_state_e;

  typedef struct packed {
    logic load;
    logic sob;
  } frame_strobe_t;

endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
  import tdm_frame_pkg::*;
#(
  parameter int TDM_FACTOR = 32,
  parameter int NUM_CHANS  = 15,
  parameter int CH_W       = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output frame_strobe_t strobe,
  output logic [CH_W-1:0] tagChan,
  output logic          errFlag
);

  localparam int MIN_GAP   = TDM_FACTOR - NUM_CHANS;
  localparam int GAP_W     = (MIN_GAP < 1) ? 1 : $clog2(MIN_GAP + 1);
  localparam int LAST_CHAN = NUM_CHANS - 1;

  frame_state_e    state, stateNext;
  logic [CH_W-1:0] chanIdx, chanNext;
  logic [GAP_W-1:0] gapCnt, gapNext;
  logic            errNext;
  logic            gapMet;

  assign gapMet  = (gapCnt >= GAP_W'(MIN_GAP));
  assign tagChan = chanIdx;

  always_comb begin
    stateNext = state;
    chanNext  = chanIdx;
    gapNext   = gapCnt;
    errNext   = errFlag;
    strobe    = '0;
    unique case (state)
      ST_WAIT_FIRST, ST_IN_GAP: begin
        if (inValid) begin
          if (state == ST_WAIT_FIRST || gapMet) begin
            strobe.load = 1'b1;
            strobe.sob  = 1'b1;
            gapNext     = '0;
            if (NUM_CHANS == 1) begin
              stateNext = ST_IN_GAP;
              chanNext  = '0;
            end else begin
              stateNext = ST_IN_BLOCK;
              chanNext  = CH_W'(1);
            end
          end else begin
            stateNext = ST_FAULT;
            errNext   = 1'b1;
          end
        end else if (state == ST_IN_GAP && !gapMet) begin
          gapNext = gapCnt + 1'b1;
        end
      end
      ST_IN_BLOCK: begin
        if (inValid) begin
          strobe.load = 1'b1;
          if (chanIdx == CH_W'(LAST_CHAN)) begin
            stateNext = ST_IN_GAP;
            chanNext  = '0;
            gapNext   = '0;
          end else begin
            chanNext = chanIdx + 1'b1;
          end
        end else begin
          stateNext = ST_FAULT;
          errNext   = 1'b1;
        end
      end
      default: begin
        stateNext = ST_FAULT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_WAIT_FIRST;
      chanIdx <= '0;
      gapCnt  <= '0;
      errFlag <= 1'b0;
    end else begin
      state   <= stateNext;
      chanIdx <= chanNext;
      gapCnt  <= gapNext;
      errFlag <= errNext;
    end
  end

endmodule

// File: rtl/tdm_frame_dpath.sv
module tdm_frame_dpath
  import tdm_frame_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  frame_strobe_t     strobe,
  input  logic [CH_W-1:0]   tagChan,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [CH_W-1:0]   outChan,
  output logic              outSob
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outChan  <= '0;
      outSob   <= 1'b0;
    end else begin
      outValid <= strobe.load;
      outSob   <= strobe.load & strobe.sob;
      if (strobe.load) begin
        outData <= inData;
        outChan <= tagChan;
      end
    end
  end

endmodule

// File: rtl/tdm_frame_checker.sv
module tdm_frame_checker
  import tdm_frame_pkg::*;
#(
  parameter int TDM_FACTOR = 32,
  parameter int NUM_CHANS  = 15,
  parameter int DATA_W     = 16,
  localparam int CH_W      = (NUM_CHANS < 2) ? 1 : $clog2(NUM_CHANS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [CH_W-1:0]   outChan,
  output logic              outSob,
  output logic              fmtError
);

  generate
    if (NUM_CHANS < 1 || NUM_CHANS > TDM_FACTOR || DATA_W < 1) begin : g_bad_params
      $fatal(1, "tdm_frame_checker: need 1 <= NUM_CHANS <= TDM_FACTOR and DATA_W >= 1");
    end
  endgenerate

  frame_strobe_t   strobe;
  logic [CH_W-1:0] tagChan;

  tdm_frame_ctrl #(
    .TDM_FACTOR(TDM_FACTOR),
    .NUM_CHANS (NUM_CHANS),
    .CH_W      (CH_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .strobe (strobe),
    .tagChan(tagChan),
    .errFlag(fmtError)
  );

  tdm_frame_dpath #(
    .DATA_W(DATA_W),
    .CH_W  (CH_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .tagChan (tagChan),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData),
    .outChan (outChan),
    .outSob  (outSob)
  );

endmodule

// File: rtl/tdm_frame_checker_sva.sv
module tdm_frame_checker_sva #(
  parameter int TDM_FACTOR = 32,
  parameter int NUM_CHANS  = 15,
  parameter int DATA_W     = 16,
  localparam int CH_W      = (NUM_CHANS < 2) ? 1 : $clog2(NUM_CHANS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic [CH_W-1:0]   outChan,
  input logic              outSob,
  input logic              fmtError
);

  // R2: a forwarded word was presented valid one cycle before, unchanged
  p_fwd_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(inValid) && outData == $past(inData)));

  // R3: start of block only with channel 0
  p_sob_chan0_r3: assert property (@(posedge clk) disable iff (!rstN)
    outSob |-> (outValid && outChan == '0));

  // R3: non-first words follow the previous channel back to back
  p_chan_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSob) |-> ($past(outValid) && outChan == CH_W'($past(outChan) + 1'b1)));

  // R9: error is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    fmtError |=> fmtError);

  // R9: nothing forwarded while in error
  p_no_fwd_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    fmtError |-> !outValid);

  // R3: channel index never leaves its range
  p_chan_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'(outChan) < NUM_CHANS));

endmodule

bind tdm_frame_checker tdm_frame_checker_sva #(
  .TDM_FACTOR(TDM_FACTOR),
  .NUM_CHANS (NUM_CHANS),
  .DATA_W    (DATA_W)
) u_sva (.*);

// File: tb/tdm_frame_checker_bench.sv
`timescale 1ns/1ps
module tdm_frame_checker_bench;

  localparam int TDM_FACTOR = 32;
  localparam int NUM_CHANS  = 15;
  localparam int DATA_W     = 16;
  localparam int CH_W       = (NUM_CHANS < 2) ? 1 : $clog2(NUM_CHANS);
  localparam int MIN_GAP    = TDM_FACTOR - NUM_CHANS;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic              outValid;
  logic [DATA_W-1:0] outData;
  logic [CH_W-1:0]   outChan;
  logic              outSob;
  logic              fmtError;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tdm_frame_checker #(
    .TDM_FACTOR(TDM_FACTOR),
    .NUM_CHANS (NUM_CHANS),
    .DATA_W    (DATA_W)
  ) u_tdm_frame_checker (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData),
    .outChan (outChan),
    .outSob  (outSob),
    .fmtError(fmtError)
  );

  function automatic bit gapIsLegal(int gap);
    return gap >= MIN_GAP;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one input cycle and sample outputs just after the edge
  task automatic step(bit v, logic [DATA_W-1:0] d);
    @(negedge clk);
    inValid = v;
    inData  = d;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(outValid == 1'b0 && fmtError == 1'b0 && outSob == 1'b0 && outChan == '0,
        "R1 reset outputs", {outValid, fmtError, outSob}, 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic goodBlock(string req);
    for (int c = 0; c < NUM_CHANS; c++) begin
      logic [DATA_W-1:0] d;
      d = DATA_W'($urandom);
      step(1'b1, d);
      chk(outValid == 1'b1, {req, " R2 valid"}, outValid, 1);
      chk(outData == d, {req, " R2 data"}, outData, d);
      chk(outChan == CH_W'(c), {req, " R3 chan"}, outChan, c);
      chk(outSob == (c == 0), {req, " R3 sob"}, outSob, (c == 0));
      chk(fmtError == 1'b0, {req, " no error"}, fmtError, 0);
    end
  endtask

  task automatic idle(int n, bit expErr, string req);
    for (int i = 0; i < n; i++) begin
      step(1'b0, '0);
      chk(outValid == 1'b0, {req, " idle no output"}, outValid, 0);
      chk(fmtError == expErr, {req, " idle error"}, fmtError, expErr);
    end
  endtask

  task automatic earlyWord(string req);
    step(1'b1, DATA_W'($urandom));
    chk(outValid == 1'b0, {req, " early word dropped"}, outValid, 0);
    @(posedge clk);
    #1;
    chk(fmtError == 1'b1, {req, " error raised"}, fmtError, 1);
  endtask

  initial begin : main
    void'($urandom(32'd20240611));
    doReset();
    // R1: first cycle after reset release
    @(posedge clk);
    #1;
    chk(outValid == 1'b0 && fmtError == 1'b0, "R1 after release", outValid, 0);

    // R4: first block with no gap
    goodBlock("R4");
    // R5: exact minimum gap
    idle(MIN_GAP, 1'b0, "R5");
    goodBlock("R5");
    // R6: longer gap
    idle(MIN_GAP + 3, 1'b0, "R6");
    goodBlock("R6");

    // random legal gaps
    for (int t = 0; t < 20; t++) begin
      idle(MIN_GAP + int'($urandom % 6), 1'b0, "R6 random");
      goodBlock("R3 random");
    end

    // R7: gap one short
    idle(MIN_GAP - 1, 1'b0, "R7");
    earlyWord("R7 short gap");
    // R9: sticky, nothing forwarded
    for (int i = 0; i < NUM_CHANS + 5; i++) begin
      step((i % 3) != 0, DATA_W'($urandom));
      chk(outValid == 1'b0, "R9 no forward after error", outValid, 0);
      chk(fmtError == 1'b1, "R9 error sticky", fmtError, 1);
    end

    // R10: reset clears error; first block needs no gap
    doReset();
    goodBlock("R10");
    // R7: zero gap
    earlyWord("R7 zero gap");

    // R8: valid drops mid-block
    doReset();
    for (int c = 0; c < 5; c++) begin
      logic [DATA_W-1:0] d;
      d = DATA_W'($urandom);
      step(1'b1, d);
      chk(outValid == 1'b1 && outChan == CH_W'(c), "R8 partial block", outChan, c);
    end
    step(1'b0, '0);
    chk(outValid == 1'b0, "R8 hole not forwarded", outValid, 0);
    for (int c = 5; c < NUM_CHANS; c++) begin
      step(1'b1, DATA_W'($urandom));
      chk(outValid == 1'b0, "R8 rest of block dropped", outValid, 0);
      chk(fmtError == 1'b1, "R8 error set", fmtError, 1);
    end

    // random gap trials around the minimum
    for (int t = 0; t < 24; t++) begin
      int gap;
      gap = int'($urandom % (MIN_GAP + 4));
      doReset();
      goodBlock("R4 trial");
      idle(gap, 1'b0, "trial gap");
      if (gapIsLegal(gap)) begin
        goodBlock("R5 trial");
      end else begin
        earlyWord("R7 trial");
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 8);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule